// File: doc/BRIEF.md
# Programmable Conversion Rate Sequencer

This block decides when a sensor front end takes a sample. A configuration write port supplies a 3-bit rate code, a shutdown bit, a single-conversion trigger bit and a write-only software reset bit. The block counts a 1 ms tick input and pulses `conv_start` to the converter. It accepts `conv_done` back and tracks whether a conversion is in flight.

With shutdown clear, the block converts continuously at the period the rate code selects. With shutdown set, it starts nothing unless a trigger write asks for exactly one conversion. Every configuration write cancels the conversion in flight. On the write cycle the block raises `conv_abort` to the converter, and it applies the new settings at once.

The period counter counts tick pulses. The `TICKS_PER_MS` parameter sets how many tick pulses make up one millisecond, so a faster tick can be used without changing the rate codes.

Top module: `conv_rate_seq`

## Requirements
- R1: After reset the read-back rate is 5, shutdown reads 0 and busy is 0. With a tick on every cycle, the first `conv_start` comes exactly 1000×TICKS_PER_MS tick cycles after reset is released.
- R2: In continuous mode, successive `conv_start` pulses are spaced by a number of ticks set by the rate code. The spacing is 15, 50, 100, 250, 500, 1000, 4000 or 16000 milliseconds, each multiplied by TICKS_PER_MS, for codes 0 to 7.
- R3: A write that leaves shutdown at 0 produces `conv_start` in the cycle right after the write cycle. The period count restarts from that start using the newly written rate.
- R4: A write that sets shutdown (without the trigger bit) produces no `conv_start` in the next cycle. No start is issued for as long as shutdown stays set, whatever the tick does.
- R5: A write with shutdown 1 and trigger 1 produces exactly one `conv_start`, in the next cycle, whatever rate code is written. No further start follows, either before or after that conversion completes.
- R6: The trigger bit always reads back as 0. When shutdown is 0, the trigger bit changes nothing: the write behaves exactly like the same write with trigger 0.
- R7: `conv_abort` is high, combinationally, in a write cycle exactly when a conversion is in flight (busy, or a start pulse in that cycle). The cycle after any write, busy is 0.
- R8: `conv_busy` rises the cycle after `conv_start` and falls the cycle after an accepted `conv_done`. A done that arrives with nothing in flight, in a write cycle, or in a start cycle is ignored.
- R9: A write with the software reset bit set restores rate 5 and shutdown 0, regardless of the other fields. It counts as a write, so a start follows in the next cycle.
- R10: Rate and shutdown read-back show the last written values from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | Time base pulse, TICKS_PER_MS pulses per millisecond |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rate | input | 3 | Rate code to write |
| cfg_shdn | input | 1 | Shutdown bit to write |
| cfg_oneshot | input | 1 | Single-conversion trigger to write |
| cfg_swrst | input | 1 | Software reset bit (write only) |
| conv_done | input | 1 | Converter signals end of conversion |
| conv_start | output | 1 | One-cycle start-conversion pulse |
| conv_abort | output | 1 | Cancel the conversion in flight (write cycle) |
| conv_busy | output | 1 | A conversion is in flight |
| rd_rate | output | 3 | Current rate code |
| rd_shdn | output | 1 | Current shutdown bit |
| rd_oneshot | output | 1 | Trigger read-back, always 0 |

## Verification
The bench measures the start spacing for all eight rate codes. A design with an off-by-one reload would show every interval one tick long or short, and a wrong table entry would break one code alone. It tests done pulses that coincide with a write or with a new start, and a stray done with nothing running. A tracker that accepted those would drop busy while a fresh conversion runs. It checks that a trigger in continuous mode adds no extra start, that a trigger in shutdown ignores the rate, and that a software reset overrides the other fields written with it. A design that let the written fields through would come back shut down or at the wrong rate.

// File: rtl/crs_pkg.sv
package crs_pkg;

    localparam int RATE_W        = 3;
    localparam int MAX_PERIOD_MS = 16000;

    typedef logic [RATE_W-1:0] rate_t;

    localparam rate_t DEFAULT_RATE = rate_t'(5);

    // Live configuration state
    typedef struct packed {
        rate_t rate;
        logic  shdn;
    } cfg_t;

    // One write on the configuration port
    typedef struct packed {
        rate_t rate;
        logic  shdn;
        logic  oneshot;
        logic  swrst;
    } cfg_wr_t;

    localparam cfg_t CFG_RESET = '{rate: DEFAULT_RATE, shdn: 1'b0};

    // Conversion period in milliseconds for each rate code
    function automatic int unsigned period_ms(rate_t code);
        case (code)
            3'd0:    return 15;
            3'd1:    return 50;
            3'd2:    return 100;
            3'd3:    return 250;
            3'd4:    return 500;
            3'd5:    return 1000;
            3'd6:    return 4000;
            default: return 16000;
        endcase
    endfunction

endpackage

// File: rtl/crs_cfg_reg.sv
module crs_cfg_reg
    import crs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  cfg_wr_t wr,
    output cfg_t    cfg_q,
    output cfg_t    cfg_d,
    output logic    run_req
);

    always_comb begin
        cfg_d   = cfg_q;
        run_req = 1'b0;
        if (we) begin
            if (wr.swrst) cfg_d = CFG_RESET;
            else          cfg_d = '{rate: wr.rate, shdn: wr.shdn};
            // continuous mode restarts; in shutdown only a trigger starts one
            run_req = !cfg_d.shdn || wr.oneshot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= cfg_d;
    end

    // R9
    swrst_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wr.swrst) |=> (cfg_q.rate == DEFAULT_RATE && !cfg_q.shdn));

    // R10
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !wr.swrst) |=> (cfg_q.rate == $past(wr.rate) && cfg_q.shdn == $past(wr.shdn)));

endmodule

// File: rtl/crs_period_timer.sv
module crs_period_timer
    import crs_pkg::*;
#(
    parameter int TICKS_PER_MS = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  wr,
    input  logic  run_req,
    input  rate_t new_rate,
    input  cfg_t  cur_cfg,
    output logic  start
);

    localparam int MAX_TICKS = MAX_PERIOD_MS * TICKS_PER_MS;
    localparam int CNT_W     = $clog2(MAX_TICKS);

    typedef logic [CNT_W-1:0] cnt_t;

    function automatic cnt_t reload(rate_t code);
        return cnt_t'(period_ms(code) * TICKS_PER_MS - 1);
    endfunction

    cnt_t cnt_q;
    logic start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            cnt_q   <= reload(DEFAULT_RATE);
        end else if (wr) begin
            start_q <= run_req;
            cnt_q   <= reload(new_rate);
        end else if (!cur_cfg.shdn && tick) begin
            if (cnt_q == '0) begin
                start_q <= 1'b1;
                cnt_q   <= reload(cur_cfg.rate);
            end else begin
                start_q <= 1'b0;
                cnt_q   <= cnt_q - 1'b1;
            end
        end else begin
            start_q <= 1'b0;
        end
    end

    assign start = start_q;

    // R3
    restart_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && run_req) |=> start_q);

    // R4
    stop_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !run_req) |=> !start_q);

    // R5
    shutdown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (start_q && cur_cfg.shdn) |-> $past(wr));

endmodule

// File: rtl/crs_conv_tracker.sv
module crs_conv_tracker (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic start,
    input  logic done,
    output logic busy,
    output logic abort
);

    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst)        busy_q <= 1'b0;
        else if (wr)    busy_q <= 1'b0;
        else if (start) busy_q <= 1'b1;
        else if (done)  busy_q <= 1'b0;
    end

    assign busy  = busy_q;
    assign abort = wr && (busy_q || start);

    // R7
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> !busy_q);

    // R8
    done_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (done && busy_q && !start && !wr) |=> !busy_q);

    // R8
    stray_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !start) |=> !busy_q);

endmodule

// File: rtl/conv_rate_seq.sv
module conv_rate_seq
    import crs_pkg::*;
#(
    parameter int TICKS_PER_MS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1ms,
    input  logic       cfg_we,
    input  logic [2:0] cfg_rate,
    input  logic       cfg_shdn,
    input  logic       cfg_oneshot,
    input  logic       cfg_swrst,
    input  logic       conv_done,
    output logic       conv_start,
    output logic       conv_abort,
    output logic       conv_busy,
    output logic [2:0] rd_rate,
    output logic       rd_shdn,
    output logic       rd_oneshot
);

    cfg_wr_t wr_bus;
    cfg_t    cfg_q;
    cfg_t    cfg_d;
    logic    run_req;
    logic    start;

    assign wr_bus = '{rate: cfg_rate, shdn: cfg_shdn, oneshot: cfg_oneshot, swrst: cfg_swrst};

    crs_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wr      (wr_bus),
        .cfg_q   (cfg_q),
        .cfg_d   (cfg_d),
        .run_req (run_req)
    );

    crs_period_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1ms),
        .wr       (cfg_we),
        .run_req  (run_req),
        .new_rate (cfg_d.rate),
        .cur_cfg  (cfg_q),
        .start    (start)
    );

    crs_conv_tracker u_track (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_we),
        .start (start),
        .done  (conv_done),
        .busy  (conv_busy),
        .abort (conv_abort)
    );

    assign conv_start = start;
    assign rd_rate    = cfg_q.rate;
    assign rd_shdn    = cfg_q.shdn;
    assign rd_oneshot = 1'b0;

endmodule

// File: tb/conv_rate_seq_bench.sv
module conv_rate_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1ms = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_rate = '0;
    logic       cfg_shdn = 1'b0;
    logic       cfg_oneshot = 1'b0;
    logic       cfg_swrst = 1'b0;
    logic       conv_done = 1'b0;
    logic       conv_start, conv_abort, conv_busy, rd_shdn, rd_oneshot;
    logic [2:0] rd_rate;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    conv_rate_seq #(.TICKS_PER_MS(1)) u_conv_rate_seq (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .cfg_we(cfg_we),
        .cfg_rate(cfg_rate), .cfg_shdn(cfg_shdn), .cfg_oneshot(cfg_oneshot),
        .cfg_swrst(cfg_swrst), .conv_done(conv_done), .conv_start(conv_start),
        .conv_abort(conv_abort), .conv_busy(conv_busy), .rd_rate(rd_rate),
        .rd_shdn(rd_shdn), .rd_oneshot(rd_oneshot)
    );

    function automatic int exp_period(int code);
        case (code)
            0: return 15;     1: return 50;    2: return 100;  3: return 250;
            4: return 500;    5: return 1000;  6: return 4000; default: return 16000;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance one clock; sample point sits 2 ns after the edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // one write cycle; exp_abort < 0 means do not check abort
    task automatic cfg_write(int rate, bit shdn, bit os, bit swrst, int exp_abort);
        cfg_we = 1'b1; cfg_rate = 3'(rate); cfg_shdn = shdn;
        cfg_oneshot = os; cfg_swrst = swrst;
        #1;
        if (exp_abort >= 0) chk("R7 abort in write cycle", int'(conv_abort), exp_abort);
        step();
        cfg_we = 1'b0; cfg_oneshot = 1'b0; cfg_swrst = 1'b0;
    endtask

    // cycles until conv_start is seen, counting from the current sample point
    task automatic cycles_to_start(int limit, output int n);
        n = 0;
        while (!conv_start && n < limit) begin
            step();
            n++;
        end
        if (!conv_start) n = -1;
    endtask

    task automatic count_starts(int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            step();
            if (conv_start) n++;
        end
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        chk("R1 reset rate", int'(rd_rate), 5);
        chk("R1 reset shutdown", int'(rd_shdn), 0);
        chk("R1 reset busy", int'(conv_busy), 0);
        chk("R6 oneshot readback", int'(rd_oneshot), 0);
        cycles_to_start(2000, n);
        chk("R1 first start after reset", n, 1000);
    endtask

    task automatic t_rates();
        int n;
        for (int code = 0; code < 8; code++) begin
            cfg_write(code, 1'b0, 1'b0, 1'b0, -1);
            chk("R3 start after write", int'(conv_start), 1);
            chk("R10 rate readback", int'(rd_rate), code);
            step();
            cycles_to_start(20000, n);
            chk("R2 period ticks", n + 1, exp_period(code));
        end
    endtask

    task automatic t_shutdown();
        int n;
        cfg_write(0, 1'b1, 1'b0, 1'b0, -1);
        chk("R4 no start after shutdown write", int'(conv_start), 0);
        chk("R10 shutdown readback", int'(rd_shdn), 1);
        chk("R7 busy cleared by write", int'(conv_busy), 0);
        count_starts(3000, n);
        chk("R4 starts while shut down", n, 0);
    endtask

    task automatic t_oneshot();
        int n;
        cfg_write(7, 1'b1, 1'b1, 1'b0, 0);
        chk("R5 single start next cycle (rate 7)", int'(conv_start), 1);
        chk("R6 oneshot reads 0", int'(rd_oneshot), 0);
        step();
        chk("R8 busy after start", int'(conv_busy), 1);
        count_starts(50, n);
        chk("R5 no extra start in flight", n, 0);
        conv_done = 1'b1;
        step();
        conv_done = 1'b0;
        chk("R8 done clears busy", int'(conv_busy), 0);
        chk("R5 still shut down", int'(rd_shdn), 1);
        count_starts(200, n);
        chk("R5 no start after completion", n, 0);
        cfg_write(0, 1'b1, 1'b1, 1'b0, 0);
        chk("R5 single start next cycle (rate 0)", int'(conv_start), 1);
        count_starts(100, n);
        chk("R5 rate ignored by oneshot", n, 0);
        conv_done = 1'b1;
        step();
        conv_done = 1'b0;
    endtask

    task automatic t_oneshot_continuous();
        int n;
        cfg_write(0, 1'b0, 1'b1, 1'b0, -1);
        chk("R6 start after continuous write", int'(conv_start), 1);
        chk("R6 oneshot reads 0 in continuous", int'(rd_oneshot), 0);
        count_starts(14, n);
        chk("R6 no extra start from trigger", n, 0);
        step();
        chk("R6 periodic start unchanged", int'(conv_start), 1);
    endtask

    task automatic t_done_edges();
        int n;
        // continuous at rate 0, converter never answered: busy is high
        step();
        chk("R8 busy in continuous", int'(conv_busy), 1);
        conv_done = 1'b1;
        cfg_write(0, 1'b0, 1'b0, 1'b0, 1);
        conv_done = 1'b0;
        chk("R7 busy 0 after abort", int'(conv_busy), 0);
        chk("R3 restart after abort", int'(conv_start), 1);
        // done during the start cycle belongs to the aborted conversion
        conv_done = 1'b1;
        step();
        conv_done = 1'b0;
        chk("R8 done in start cycle ignored", int'(conv_busy), 1);
        conv_done = 1'b1;
        step();
        conv_done = 1'b0;
        chk("R8 done accepted", int'(conv_busy), 0);
        // idle write must not abort
        cfg_write(0, 1'b1, 1'b0, 1'b0, 0);
        conv_done = 1'b1;
        step();
        conv_done = 1'b0;
        step();
        chk("R8 stray done ignored", int'(conv_busy), 0);
        count_starts(40, n);
        chk("R4 still quiet", n, 0);
    endtask

    task automatic t_swreset();
        int n;
        cfg_write(2, 1'b1, 1'b0, 1'b0, 0);
        cfg_write(7, 1'b1, 1'b0, 1'b1, 0);
        chk("R9 start after soft reset", int'(conv_start), 1);
        chk("R9 rate restored", int'(rd_rate), 5);
        chk("R9 shutdown cleared", int'(rd_shdn), 0);
        step();
        cycles_to_start(2000, n);
        chk("R9 default period", n + 1, 1000);
    endtask

    initial begin
        #(8 * 190000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_rates();
        t_shutdown();
        t_oneshot();
        t_oneshot_continuous();
        t_done_edges();
        t_swreset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule